// File: doc/BRIEF.md
# Chained Two-or-Three Programmable Clock Divider

This block divides an input clock by a programmable integer. It is a chain of identical cells. Each cell normally passes one output step for every two input steps it receives. Once per overall output period it can stretch one of its own periods to three input steps. The first cell runs on every input clock. Every later cell advances only on the steps of the cell before it. The last cell's step marks the end of an output period, and a registered one-cycle pulse on the output reports it.

No central controller decides when a cell may stretch. Each cell holds a qualification bit of its own and sends a mode signal to the faster cell in front of it. The slowest cell's mode input is held active. The mode signal therefore travels down the chain once per output period, and every cell whose ratio bit is set adds exactly one of its own input periods. That adds 2^i input clocks for cell i. All logic runs synchronously on the input clock, and each cell's step acts as the clock enable of the next cell.

The ratio word is captured while reset is active and again at each output-period boundary, and it is held between those points. A period therefore never mixes two ratios.

Top module: `mmd_divider`

## Requirements
- R1: With NUM_STAGES = n cells and ratio word c (bit i controls cell i, bit 0 the fastest cell), `div_out` pulses once every 2^n + c cycles of `clk`.
- R2: Ratio word zero gives a period of 2^n, and the all-ones word gives 2^(n+1) - 1. Every word between them gives a distinct period.
- R3: A cell enters its stretch phase only from its second phase, and only when its qualification bit was set and its input step was present.
- R4: The mode input of the slowest cell is permanently active, so every set ratio bit takes effect once in every output period.
- R5: A ratio word presented in the middle of a period does not change that period. It takes effect from the period that starts after the next `div_out` pulse.
- R6: While `rst_n` is low, `div_out` stays low and the ratio word is captured. The first period after release, counted from the first rising edge after release to the first pulse, equals the programmed length.
- R7: A cell's mode output is active for exactly one step of its input enable per output period, and the first cell's mode output is active for exactly one clock per output period.
- R8: A cell's qualification bit is cleared when it enters the stretch phase, so that only one extra input step is swallowed per period.
- R9: `div_out` is high for exactly one clock cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; captures the ratio word |
| ratio | input | NUM_STAGES | Ratio word; the period is 2^NUM_STAGES + ratio |
| div_out | output | 1 | One-cycle pulse marking the end of each output period |

## Verification
The bench builds the divider with four cells instead of the default three. This makes all sixteen ratio words reachable, covering periods 16 to 31, and puts the mode signal through three cell-to-cell hand-offs. Each word is applied right after a pulse. The period that follows must still show the previous ratio, and the next two must show the new one. The bench also changes the word in the middle of a period and applies reset while the divider is running. This exercises both the boundary rule on the ratio word and the length of the first period after reset.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_X = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   qual;
    } cell_state_t;

    typedef struct packed {
        logic pulse;
        logic [1:0] head_cnt;
    } top_state_t;

endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic swallow_req_i,
    input  logic mode_i,
    output logic step_o,
    output logic mode_o
);

    cell_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            unique case (st_q.ph)
                PH_A: begin
                    st_d.ph   = PH_B;
                    st_d.qual = mode_i & swallow_req_i;
                end
                PH_B: begin
                    if (st_q.qual) begin
                        st_d.ph   = PH_X;
                        st_d.qual = 1'b0;
                    end else begin
                        st_d.ph = PH_A;
                    end
                end
                default: begin
                    st_d.ph   = PH_A;
                    st_d.qual = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_A, qual: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = step_i & (((st_q.ph == PH_B) & ~st_q.qual) | (st_q.ph == PH_X));
    assign mode_o = mode_i & (st_q.ph == PH_B);

    // R3: the stretch phase is reached only from a qualified second phase
    p_stretch_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_X && $past(st_q.ph) != PH_X) |->
            $past(st_q.ph == PH_B && st_q.qual && step_i));

    // R8: qualification is gone once the stretch phase is entered
    p_qual_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_X) |-> !st_q.qual);

    // R7: mode output drops after the input step that ends its phase
    p_mode_one_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o && step_i) |=> !mode_o);

endmodule

// File: rtl/mmd_ratio_hold.sv
module mmd_ratio_hold #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] ratio_i,
    output logic [WIDTH-1:0] ratio_o
);

    logic [WIDTH-1:0] word_q, word_d;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = ratio_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q <= ratio_i;
        end else begin
            word_q <= word_d;
        end
    end

    assign ratio_o = word_q;

    // R5: the held word changes only at a period boundary
    p_word_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(word_q));

endmodule

// File: rtl/mmd_divider.sv
module mmd_divider
    import mmd_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] ratio,
    output logic                  div_out
);

    localparam int unsigned LAST = NUM_STAGES - 1;

    logic [NUM_STAGES:0]   step_chain;
    logic [NUM_STAGES:0]   mode_chain;
    logic [NUM_STAGES-1:0] ratio_held;
    logic                  period_end;

    top_state_t top_q, top_d;

    assign step_chain[0]          = 1'b1;
    assign mode_chain[NUM_STAGES] = 1'b1;
    assign period_end             = step_chain[NUM_STAGES];

    mmd_ratio_hold #(.WIDTH(NUM_STAGES)) u_hold (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .load_i  (period_end),
        .ratio_i (ratio),
        .ratio_o (ratio_held)
    );

    for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_cell
        mmd_cell u_cell (
            .clk_i         (clk),
            .rst_ni        (rst_n),
            .step_i        (step_chain[gi]),
            .swallow_req_i (ratio_held[gi]),
            .mode_i        (mode_chain[gi+1]),
            .step_o        (step_chain[gi+1]),
            .mode_o        (mode_chain[gi])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.pulse = period_end;
        if (period_end) begin
            top_d.head_cnt = 2'd0;
        end else if (mode_chain[0] && top_q.head_cnt != 2'd3) begin
            top_d.head_cnt = top_q.head_cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '{pulse: 1'b0, head_cnt: 2'd0};
        end else begin
            top_q <= top_d;
        end
    end

    assign div_out = top_q.pulse;

    // R9: the output pulse lasts one clock
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R7 and R4: head mode seen exactly once in every output period
    p_head_mode_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> ({1'b0, top_q.head_cnt} + {2'b00, mode_chain[0]} == 3'd1));

    // R1: the slowest cell steps only together with the head cell's step
    p_end_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_chain[LAST+1] |-> step_chain[1]);

endmodule

// File: tb/tb_mmd_divider.sv
module tb_mmd_divider;

    localparam int STAGES = 4;
    localparam int BASE   = 1 << STAGES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [STAGES-1:0] ratio = '0;
    logic              div_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // {ratio word, expected period}
    localparam logic [15:0] VEC [16] = '{
        {8'd0,  8'd16}, {8'd15, 8'd31}, {8'd5,  8'd21}, {8'd10, 8'd26},
        {8'd3,  8'd19}, {8'd12, 8'd28}, {8'd7,  8'd23}, {8'd8,  8'd24},
        {8'd1,  8'd17}, {8'd14, 8'd30}, {8'd6,  8'd22}, {8'd9,  8'd25},
        {8'd2,  8'd18}, {8'd13, 8'd29}, {8'd4,  8'd20}, {8'd11, 8'd27}
    };

    mmd_divider #(.NUM_STAGES(STAGES)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio   (ratio),
        .div_out (div_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic next_gap(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!div_out && gap < 200);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int gap;
        int prev;
        int seen;

        // R6: reset holds the output low and captures the word
        ratio = 4'd9;
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (div_out) seen++;
        end
        check("R6 output low in reset", seen, 0);
        rst_n = 1'b1;
        next_gap(gap);
        check("R6 first period after release", gap, BASE + 9);
        next_gap(gap);
        check("R1 steady period word 9", gap, BASE + 9);
        prev = BASE + 9;

        // R1 R2 R5: walk every ratio word
        for (int k = 0; k < 16; k++) begin
            ratio = VEC[k][11:8];
            next_gap(gap);
            check("R5 boundary period keeps old word", gap, prev);
            next_gap(gap);
            check("R1 period after word change", gap, int'(VEC[k][7:0]));
            next_gap(gap);
            check("R1 R4 repeated period", gap, int'(VEC[k][7:0]));
            prev = int'(VEC[k][7:0]);
        end

        // R2: end points of the range
        ratio = '0;
        next_gap(gap);
        next_gap(gap);
        check("R2 smallest ratio", gap, BASE);
        ratio = '1;
        next_gap(gap);
        next_gap(gap);
        check("R2 largest ratio", gap, 2 * BASE - 1);

        // R5: change the word in the middle of a period
        repeat (7) @(negedge clk);
        ratio = 4'd2;
        next_gap(gap);
        check("R5 mid-period change ignored", gap, 2 * BASE - 1 - 7);
        next_gap(gap);
        check("R5 new word after boundary", gap, BASE + 2);

        // R9: pulse width is one cycle
        @(negedge clk);
        check("R9 pulse low next cycle", int'(div_out), 0);

        // R6: reset while running, then the first period
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        ratio = 4'd6;
        @(negedge clk);
        @(negedge clk);
        check("R6 output low during mid-run reset", int'(div_out), 0);
        rst_n = 1'b1;
        next_gap(gap);
        check("R6 first period after mid-run reset", gap, BASE + 6);
        next_gap(gap);
        check("R1 R3 R8 steady after reset", gap, BASE + 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule